// File: doc/BRIEF.md
# DAC Update Latch Controller

This block is the digital side of one 12-bit digital-to-analog channel. Software loads a value through a small register bus as two bytes, a low byte and a high byte, into staging registers. A second register, the converter output register, drives the 12-bit code to the analog stage. The value moves from staging to output only when a chosen transfer event occurs. That event is either a write to the high byte or an overflow pulse from one of three timers. Timer-paced updates let a waveform advance at a steady rate, whatever the software latency.

A control register holds three things: an enable bit, a two-bit update mode and a three-bit format code. The format code says where the 12 significant bits sit within the 16-bit byte pair, either packed against the bottom or packed against the top. While the channel is disabled, the output code is zero and transfer events are ignored. Software can still fill the staging registers, so a first value is ready before the channel is switched on.

Top module: `dac_latch_ctrl`

## Requirements
- R1: After reset the control register, both staging bytes and the output code are zero, and reads of every address return zero.
- R2: With update mode 0 (control bits 4..3 = 00), a write to the high byte at address 2 loads the output code at that clock edge. The code is built from the byte just written and the current low byte. A write to the low byte alone leaves the output unchanged.
- R3: Update modes 1, 2 and 3 load the output on a pulse of `tmr3_ovf`, `tmr4_ovf` and `tmr2_ovf` respectively. In these modes byte writes and pulses of the other two timers leave the output unchanged.
- R4: Format code 111 (control bits 2..0) gives the code {high[7:0], low[7:4]}.
- R5: Format code 000 gives the code {high[3:0], low[7:0]}. Every other format code is treated the same way as 000.
- R6: While the enable bit (control bit 7) is 0, `dac_code` is zero, transfer events are ignored and the staging bytes can still be written. After re-enabling, the code stays zero until the next transfer event.
- R7: The register map is: address 0 control, 1 low byte, 2 high byte. A read of control returns enable in bit 7, mode in bits 4..3, format in bits 2..0, and zeros in bits 6..5. Reads of the byte addresses return the full staged bytes. Address 3 reads zero, and writes to it are ignored.
- R8: When a byte write and the selected timer pulse fall in the same cycle, the output takes the staging value that includes that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| tmr3_ovf | input | 1 | Overflow pulse, selected by mode 1 |
| tmr4_ovf | input | 1 | Overflow pulse, selected by mode 2 |
| tmr2_ovf | input | 1 | Overflow pulse, selected by mode 3 |
| dac_code | output | 12 | Code to the converter |

## Verification
A transfer event sampled at a rising edge shows on `dac_code` right after that edge, with no extra stage. Likewise, a control write that disables the channel forces the code to zero right after its edge. The bench drives every write and pulse for exactly one cycle from a falling edge and compares the result at the next falling edge. Read data is combinational from `addr`, so readbacks are checked a short delay after the address changes, with no clock in between. The sweep covers all four modes against formats 000, 111 and one other code.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;

   // register addresses
   localparam int REG_CTRL = 0;
   localparam int REG_LO   = 1;
   localparam int REG_HI   = 2;

   // control byte field positions
   localparam int CTRL_EN_BIT   = 7;
   localparam int CTRL_MODE_LSB = 3;
   localparam int CTRL_FMT_LSB  = 0;

   localparam logic [2:0] FMT_LEFT = 3'b111;

   typedef enum logic [1:0] {
      UPD_ON_HIGH = 2'd0,
      UPD_TMR3    = 2'd1,
      UPD_TMR4    = 2'd2,
      UPD_TMR2    = 2'd3
   } upd_mode_e;

   typedef struct packed {
      logic       en;
      upd_mode_e  mode;
      logic [2:0] fmt;
   } ctrl_t;

endpackage

// File: rtl/dlc_regbank.sv
module dlc_regbank
   import dac_latch_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wr_data,
   output ctrl_t             ctrl_q,
   output logic [BYTE_W-1:0] lo_d,
   output logic [BYTE_W-1:0] hi_d,
   output logic              hi_wr,
   output logic [BYTE_W-1:0] rd_data
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(REG_LO);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(REG_HI);

   logic              sel_ctrl, sel_lo, sel_hi;
   logic [BYTE_W-1:0] lo_q, hi_q;
   ctrl_t             ctrl_d;
   logic [BYTE_W-1:0] ctrl_rd;

   always_comb begin
      sel_ctrl = wr_en && (addr == A_CTRL);
      sel_lo   = wr_en && (addr == A_LO);
      sel_hi   = wr_en && (addr == A_HI);
   end

   assign hi_wr = sel_hi;

   // next-state values of the staging bytes (post-write view)
   always_comb begin
      lo_d = sel_lo ? wr_data : lo_q;
      hi_d = sel_hi ? wr_data : hi_q;
   end

   always_comb begin
      ctrl_d = ctrl_q;
      if (sel_ctrl) begin
         ctrl_d.en   = wr_data[CTRL_EN_BIT];
         ctrl_d.mode = upd_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
         ctrl_d.fmt  = wr_data[CTRL_FMT_LSB +: 3];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         ctrl_q <= '0;
      end else begin
         lo_q   <= lo_d;
         hi_q   <= hi_d;
         ctrl_q <= ctrl_d;
      end
   end

   always_comb begin
      ctrl_rd                        = '0;
      ctrl_rd[CTRL_EN_BIT]           = ctrl_q.en;
      ctrl_rd[CTRL_MODE_LSB +: 2]    = ctrl_q.mode;
      ctrl_rd[CTRL_FMT_LSB +: 3]     = ctrl_q.fmt;
   end

   always_comb begin
      unique case (addr)
         A_CTRL:  rd_data = ctrl_rd;
         A_LO:    rd_data = lo_q;
         A_HI:    rd_data = hi_q;
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/dlc_event_sel.sv
module dlc_event_sel
   import dac_latch_pkg::*;
#(
   parameter int N_TMR  = 3,
   parameter int MODE_W = 2
) (
   input  upd_mode_e        mode,
   input  logic             hi_wr,
   input  logic [N_TMR-1:0] tmr_ovf,
   output logic             fire
);

   localparam int N_SRC = N_TMR + 1;

   logic [N_SRC-1:0] src;

   assign src[0] = hi_wr;

   for (genvar i = 0; i < N_TMR; i++) begin : g_src
      assign src[i+1] = tmr_ovf[i];
   end

   if (N_SRC != (1 << MODE_W)) begin : g_bad_src
      $error("dlc_event_sel: source count must fill the mode field");
   end

   assign fire = src[MODE_W'(mode)];

endmodule

// File: rtl/dlc_justify.sv
module dlc_justify
   import dac_latch_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CODE_W = 12
) (
   input  logic [BYTE_W-1:0] hi,
   input  logic [BYTE_W-1:0] lo,
   input  logic [2:0]        fmt,
   output logic [CODE_W-1:0] code
);

   localparam int PAIR_W = 2 * BYTE_W;

   logic [PAIR_W-1:0] pair;
   assign pair = {hi, lo};

   if (CODE_W == PAIR_W) begin : g_full
      // full-width code: justification is a no-op
      logic unused_fmt;
      assign unused_fmt = ^fmt;
      assign code       = pair;
   end else begin : g_mux
      logic [CODE_W-1:0] right_c, left_c;
      assign right_c = pair[CODE_W-1:0];
      assign left_c  = pair[PAIR_W-1 -: CODE_W];
      assign code    = (fmt == FMT_LEFT) ? left_c : right_c;
   end

endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
   import dac_latch_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CODE_W = 12,
   parameter int ADDR_W = 2,
   parameter int N_TMR  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              tmr3_ovf,
   input  logic              tmr4_ovf,
   input  logic              tmr2_ovf,
   output logic [CODE_W-1:0] dac_code
);

   localparam int MODE_W = 2;

   if (BYTE_W < 8) begin : g_bad_byte
      $error("dac_latch_ctrl: control layout needs at least 8-bit bytes");
   end
   if (CODE_W <= BYTE_W || CODE_W > 2 * BYTE_W) begin : g_bad_code
      $error("dac_latch_ctrl: code width must lie above one byte and within two");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("dac_latch_ctrl: three registers need a 2-bit address");
   end
   if (N_TMR != 3) begin : g_bad_tmr
      $error("dac_latch_ctrl: three timer sources are wired at the ports");
   end

   ctrl_t             ctrl_q;
   logic [BYTE_W-1:0] lo_d, hi_d;
   logic              hi_wr;
   logic              fire;
   logic [N_TMR-1:0]  tmr_vec;
   logic [CODE_W-1:0] next_code;
   logic [CODE_W-1:0] out_q;
   logic              en;

   assign tmr_vec = {tmr2_ovf, tmr4_ovf, tmr3_ovf};
   assign en      = ctrl_q.en;

   dlc_regbank #(
      .BYTE_W (BYTE_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .ctrl_q  (ctrl_q),
      .lo_d    (lo_d),
      .hi_d    (hi_d),
      .hi_wr   (hi_wr),
      .rd_data (rd_data)
   );

   dlc_event_sel #(
      .N_TMR  (N_TMR),
      .MODE_W (MODE_W)
   ) u_evt (
      .mode    (ctrl_q.mode),
      .hi_wr   (hi_wr),
      .tmr_ovf (tmr_vec),
      .fire    (fire)
   );

   dlc_justify #(
      .BYTE_W (BYTE_W),
      .CODE_W (CODE_W)
   ) u_just (
      .hi   (hi_d),
      .lo   (lo_d),
      .fmt  (ctrl_q.fmt),
      .code (next_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (!en) begin
         out_q <= '0;
      end else if (fire) begin
         out_q <= next_code;
      end
   end

   assign dac_code = en ? out_q : '0;

endmodule

// File: rtl/dlc_checker.sv
module dlc_checker
   import dac_latch_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CODE_W = 12,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [BYTE_W-1:0] wr_data,
   input logic [BYTE_W-1:0] rd_data,
   input logic [BYTE_W-1:0] lo_d,
   input logic              en,
   input upd_mode_e         mode,
   input logic [2:0]        fmt,
   input logic              fire,
   input logic [CODE_W-1:0] dac_code
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(REG_LO);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(REG_HI);

   logic [2*BYTE_W-1:0] pair_w;
   logic [CODE_W-1:0]   right_w, left_w;
   logic                hi_write;

   assign pair_w   = {wr_data, lo_d};
   assign right_w  = pair_w[CODE_W-1:0];
   assign left_w   = pair_w[2*BYTE_W-1 -: CODE_W];
   assign hi_write = wr_en && (addr == A_HI);

   assert_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> dac_code == '0);

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !fire && !(wr_en && addr == A_CTRL)) |=> $stable(dac_code));

   assert_high_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == UPD_ON_HIGH && hi_write && fmt != FMT_LEFT) |=> dac_code == $past(right_w));

   assert_high_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == UPD_ON_HIGH && hi_write && fmt == FMT_LEFT) |=> dac_code == $past(left_w));

   assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_LO) |=> (addr != A_LO || rd_data == $past(wr_data)));

endmodule

bind dac_latch_ctrl dlc_checker #(
   .BYTE_W (BYTE_W),
   .CODE_W (CODE_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .lo_d     (lo_d),
   .en       (en),
   .mode     (ctrl_q.mode),
   .fmt      (ctrl_q.fmt),
   .fire     (fire),
   .dac_code (dac_code)
);

// File: tb/tb_dac_latch_ctrl.sv
module tb_dac_latch_ctrl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [7:0]  wr_data = 8'd0;
   logic [7:0]  rd_data;
   logic        tmr3_ovf = 1'b0;
   logic        tmr4_ovf = 1'b0;
   logic        tmr2_ovf = 1'b0;
   logic [11:0] dac_code;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model state
   int m_en = 0, m_mode = 0, m_fmt = 0, m_lo = 0, m_hi = 0, m_out = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_latch_ctrl dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .tmr3_ovf (tmr3_ovf),
      .tmr4_ovf (tmr4_ovf),
      .tmr2_ovf (tmr2_ovf),
      .dac_code (dac_code)
   );

   function automatic int calc(input int h, input int l, input int f);
      if (f == 7) return h * 16 + l / 16;
      return (h % 16) * 256 + l;
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic check_out(input string tag);
      check(tag, int'(dac_code), (m_en != 0) ? m_out : 0);
   endtask

   task automatic read_chk(input string tag, input int a, input int exp);
      addr = a[1:0];
      #1;
      check(tag, int'(rd_data), exp);
   endtask

   // one cycle of stimulus: optional write plus timer mask {t2,t4,t3}
   task automatic step(input bit w, input int a, input int d, input int tm);
      bit ev;
      @(negedge clk);
      wr_en    = w;
      addr     = a[1:0];
      wr_data  = d[7:0];
      tmr3_ovf = tm[0];
      tmr4_ovf = tm[1];
      tmr2_ovf = tm[2];
      ev = (m_mode == 0 && w && a == 2) ||
           (m_mode == 1 && tm[0]) || (m_mode == 2 && tm[1]) || (m_mode == 3 && tm[2]);
      if (w && a == 1) m_lo = d & 255;
      if (w && a == 2) m_hi = d & 255;
      if (m_en == 0) m_out = 0;
      else if (ev) m_out = calc(m_hi, m_lo, m_fmt);
      if (w && a == 0) begin
         m_en   = (d >> 7) & 1;
         m_mode = (d >> 3) & 3;
         m_fmt  = d & 7;
      end
      @(negedge clk);
      wr_en    = 1'b0;
      tmr3_ovf = 1'b0;
      tmr4_ovf = 1'b0;
      tmr2_ovf = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 reset code", int'(dac_code), 0);
      for (int a = 0; a < 4; a++) read_chk("R1 reset read", a, 0);

      // sweep modes x formats (R2 R3 R4 R5 R7)
      for (int m = 0; m < 4; m++) begin
         for (int fi = 0; fi < 3; fi++) begin
            int f  = (fi == 0) ? 0 : (fi == 1) ? 7 : 5;
            int l  = (8'h3C ^ (m * 37 + f * 11)) & 255;
            int h  = (8'hA5 + m * 19 + f) & 255;
            int cw = 128 + m * 8 + f;
            step(1, 0, cw, 0);
            read_chk("R7 ctrl readback", 0, cw);
            step(1, 1, l, 0);
            check_out((m == 0) ? "R2 low write holds" : "R3 low write holds");
            step(1, 2, h, 0);
            check_out((m == 0) ? ((f == 7) ? "R4 high write left" : "R5 high write right")
                               : "R3 high write holds");
            for (int t = 0; t < 3; t++) begin
               l = (l + 29) & 255;
               step(1, 1, l, 0);
               step(0, 0, 0, 1 << t);
               check_out((m == t + 1) ? ((f == 7) ? "R4 timer left" : "R3 timer transfer")
                                      : "R3 other timer ignored");
            end
            read_chk("R7 low readback", 1, m_lo);
            read_chk("R7 high readback", 2, m_hi);
         end
      end

      // R7: unused address
      step(1, 3, 8'h5A, 0);
      read_chk("R7 addr3 reads zero", 3, 0);
      read_chk("R7 addr3 write ignored lo", 1, m_lo);
      read_chk("R7 addr3 write ignored hi", 2, m_hi);
      read_chk("R7 ctrl unused bits", 0, m_en * 128 + m_mode * 8 + m_fmt);
      step(1, 0, 8'hE0 | (1 << 3), 0);
      read_chk("R7 ctrl bits 6..5 zero", 0, 128 + 8);

      // R8: write and selected pulse in one cycle (mode 1, right)
      step(1, 1, 8'h9B, 0);
      step(1, 2, 8'h7E, 1);
      check("R8 same-cycle write", int'(dac_code), calc(8'h7E, 8'h9B, 0));
      step(1, 1, 8'h42, 1);
      check("R8 same-cycle low write", int'(dac_code), calc(8'h7E, 8'h42, 0));

      // R6: disable behaviour
      step(1, 0, 8'h08, 0);
      check("R6 disable zeroes code", int'(dac_code), 0);
      step(0, 0, 0, 7);
      check("R6 events ignored", int'(dac_code), 0);
      step(1, 2, 8'hC3, 0);
      read_chk("R6 staging writable", 2, 8'hC3);
      step(1, 0, 8'h88, 0);
      check("R6 re-enable starts zero", int'(dac_code), 0);
      step(0, 0, 0, 1);
      check("R6 first event after enable", int'(dac_code), calc(8'hC3, 8'h42, 0));
      check_out("R6 model agrees");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule